// File: doc/BRIEF.md
# Serial Port Modem Control and Status Registers

This block holds the modem-control byte of a serial port and builds the modem-status byte that a host reads back. A single write strobe loads the control byte, which drives the four active-low handshake outputs: data-terminal-ready, request-to-send and two auxiliary outputs. The four active-low handshake inputs (clear-to-send, data-set-ready, ring indicator and carrier detect) pass through a two-flop synchronizer. The block then reports their current levels and a set of sticky change bits.

A read strobe returns the status byte and clears the change bits in the same cycle. An input edge that lands in that cycle is still recorded. A one-cycle change flag pulses whenever a change bit goes from 0 to 1, so a status reporter can tell when to send a fresh status byte.

A loopback mode is selected by a control bit. In this mode the control outputs feed the status inputs inside the block, the external inputs are ignored and the external outputs are held inactive. This allows the handshake path to be tested without any cabling.

Top module: `modem_ctl_stat`

## Requirements
- R1: Control bit 0 selects DTR and bit 1 selects RTS. A 1 drives `dtr_n` or `rts_n` low after the write edge, and a 0 drives it high. Writing 0x08 leaves both high, 0x09 drives only `dtr_n` low, and 0x0A drives only `rts_n` low.
- R2: Control bit 2 drives `out1_n` and bit 3 drives `out2_n`, each low when the bit is 1. Control bits 7 to 5 have no effect on any output.
- R3: Status bits 7, 6, 5 and 4 report whether DCD, RI, DSR and CTS are asserted (pin low). Each reflects its pin two clock edges after the pin changes.
- R4: Status bits 3, 1 and 0 are set when DCD, DSR or CTS respectively has changed level at least once since the last status read. They stay set until a read.
- R5: Status bit 2 is set only when RI goes from asserted to released (pin low to high). Asserting RI does not set it.
- R6: A read returns the level bits and the change bits as they stood before the read edge. It clears the change bits, except for any change detected on that same edge, which stays set.
- R7: While control bit 4 is 1, the status levels come from the control byte: RTS to CTS, DTR to DSR, OUT1 to RI and OUT2 to DCD. The external inputs are ignored, and all four output pins are held high.
- R8: `chg_flag` is high for exactly one cycle after any status change bit goes from 0 to 1. It stays low while the bits that change are already set.
- R9: After reset the control byte is 0, all four output pins are high, `chg_flag` is low and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load the control byte from `wr_data` |
| wr_data | input | 8 | Control byte |
| rd_en | input | 1 | Read the status byte and clear the change bits |
| rd_data | output | 8 | Status byte captured on the last read |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| out1_n | output | 1 | Auxiliary output 1, active low |
| out2_n | output | 1 | Auxiliary output 2, active low |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| chg_flag | output | 1 | One-cycle pulse when a change bit newly sets |

## Verification
The control byte is stepped through the three standard handshake values, the auxiliary bits and a byte with the reserved bits set. At each step the inputs change one line at a time, so each change bit can be traced to one line. RI is first asserted and then released, which separates trailing-edge detection from plain change detection. The loopback steps drive the external inputs to the opposite state, which shows that only the control byte feeds the status. Directed cases place an input edge on the exact read edge, and toggle a line whose change bit is already set, to separate merge-on-read and the 0-to-1 rule of the change flag from simpler behaviour.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int LINES    = 4;
  localparam int BYTE_W   = 8;
  localparam int C_DTR    = 0;
  localparam int C_RTS    = 1;
  localparam int C_OUT1   = 2;
  localparam int C_OUT2   = 3;
  localparam int C_LOOP   = 4;
  localparam int CTRL_W   = 5;

  // asserted-high view of the handshake inputs; order matches status bits 7..4
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } lines_t;
endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CHAIN_W-WIDTH-1:0], d};
      end
    end
  endgenerate

  assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
  import mcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_bits,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      dtr_n  <= 1'b1;
      rts_n  <= 1'b1;
      out1_n <= 1'b1;
      out2_n <= 1'b1;
    end else if (wr_en) begin
      ctrl_q <= wr_bits;
      dtr_n  <= wr_bits[C_LOOP] | ~wr_bits[C_DTR];
      rts_n  <= wr_bits[C_LOOP] | ~wr_bits[C_RTS];
      out1_n <= wr_bits[C_LOOP] | ~wr_bits[C_OUT1];
      out2_n <= wr_bits[C_LOOP] | ~wr_bits[C_OUT2];
    end
  end

  // R7: loopback keeps every external output inactive
  a_r7_loop_pins_idle: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[C_LOOP] |-> (dtr_n && rts_n && out1_n && out2_n));

  // R1: a normal write drives DTR to the complement of bit 0
  a_r1_dtr_follows: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_bits[C_LOOP]) |=> (dtr_n == !$past(wr_bits[C_DTR])));
endmodule

// File: rtl/mcs_delta.sv
module mcs_delta
  import mcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  lines_t            cur,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              chg_flag
);
  lines_t            prev;
  logic [LINES-1:0]  delta;
  logic [LINES-1:0]  edges;
  logic [LINES-1:0]  delta_nx;

  // change bits in status order: dcd change, ri trailing, dsr change, cts change
  always_comb begin
    edges[3] = cur.dcd ^ prev.dcd;
    edges[2] = prev.ri & ~cur.ri;
    edges[1] = cur.dsr ^ prev.dsr;
    edges[0] = cur.cts ^ prev.cts;
    delta_nx = rd_en ? edges : (delta | edges);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev     <= '0;
      delta    <= '0;
      rd_data  <= '0;
      chg_flag <= 1'b0;
    end else begin
      prev     <= cur;
      delta    <= delta_nx;
      chg_flag <= |(delta_nx & ~delta);
      if (rd_en) rd_data <= {cur, delta};
    end
  end

  // R6: a read with no new edge leaves all change bits clear
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (edges == '0)) |=> (delta == '0));

  // R4: without a read, no change bit falls
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ((delta & $past(delta)) == $past(delta)));

  // R5: the RI change bit only rises after RI was released
  a_r5_ri_trailing: assert property (@(posedge clk) disable iff (rst)
    $rose(delta[2]) |-> $past(prev.ri && !cur.ri));

  // R8: the change flag only pulses when some change bit is set
  a_r8_flag_has_bit: assert property (@(posedge clk) disable iff (rst)
    chg_flag |-> (delta != '0));
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
  import mcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       out1_n,
  output logic       out2_n,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       chg_flag
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [LINES-1:0]  pins_asserted;
  logic [LINES-1:0]  synced;
  lines_t            ext_lines;
  lines_t            loop_lines;
  lines_t            cur;
  logic              unused_reserved;

  assign unused_reserved = ^wr_data[BYTE_W-1:CTRL_W];

  mcs_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_bits(wr_data[CTRL_W-1:0]),
    .ctrl_q (ctrl_q),
    .dtr_n  (dtr_n),
    .rts_n  (rts_n),
    .out1_n (out1_n),
    .out2_n (out2_n)
  );

  assign pins_asserted = ~{dcd_n, ri_n, dsr_n, cts_n};

  mcs_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (pins_asserted),
    .q  (synced)
  );

  always_comb begin
    ext_lines      = lines_t'(synced);
    loop_lines.dcd = ctrl_q[C_OUT2];
    loop_lines.ri  = ctrl_q[C_OUT1];
    loop_lines.dsr = ctrl_q[C_DTR];
    loop_lines.cts = ctrl_q[C_RTS];
    cur            = ctrl_q[C_LOOP] ? loop_lines : ext_lines;
  end

  mcs_delta u_delta (
    .clk     (clk),
    .rst     (rst),
    .cur     (cur),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .chg_flag(chg_flag)
  );
endmodule

// File: tb/modem_ctl_stat_bench.sv
module modem_ctl_stat_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       dtr_n, rts_n, out1_n, out2_n;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic       chg_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  modem_ctl_stat u_modem_ctl_stat (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n),
    .out2_n(out2_n), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
    .dcd_n(dcd_n), .chg_flag(chg_flag)
  );

  // {ctrl byte, inputs {dcd_n,ri_n,dsr_n,cts_n}, expected {out2_n,out1_n,rts_n,dtr_n}, expected status}
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {8'h08, 4'b1111, 4'b0111, 8'h00},
    {8'h09, 4'b1110, 4'b0110, 8'h11},
    {8'h0A, 4'b1100, 4'b0101, 8'h32},
    {8'h03, 4'b1000, 4'b1100, 8'h70},
    {8'h0C, 4'b1100, 4'b0011, 8'h34},
    {8'h00, 4'b0100, 4'b1111, 8'hB8},
    {8'hE1, 4'b1111, 4'b1110, 8'h0B},
    {8'h10, 4'b0000, 4'b1111, 8'h00},
    {8'h12, 4'b1111, 4'b1111, 8'h11},
    {8'h1F, 4'b1111, 4'b1111, 8'hFA},
    {8'h1B, 4'b1111, 4'b1111, 8'hB4},
    {8'h08, 4'b1111, 4'b0111, 8'h0B}
  };
  localparam string TAG [NV] = '{
    "R1", "R1 R3 R4", "R1 R4", "R2 R3", "R2 R5", "R2 R4",
    "R2 R4", "R7", "R7", "R7 R4", "R7 R5", "R7 R4"
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic do_read();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] pins_out();
    return {4'b0000, out2_n, out1_n, rts_n, dtr_n};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9", "pins after reset", pins_out(), 8'h0F);
    check("R9", "chg after reset", {7'b0, chg_flag}, 8'h00);
    check("R9", "rd_data after reset", rd_data, 8'h00);
    do_read();
    check("R9", "first read", rd_data, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr_en   = 1'b1;
      wr_data = VEC[i][23:16];
      {dcd_n, ri_n, dsr_n, cts_n} = VEC[i][15:12];
      @(negedge clk);
      wr_en = 1'b0;
      repeat (5) @(negedge clk);
      check(TAG[i], $sformatf("pins step %0d", i), pins_out(), {4'b0, VEC[i][11:8]});
      do_read();
      check(TAG[i], $sformatf("status step %0d", i), rd_data, VEC[i][7:0]);
    end

    // R8 change flag: one pulse on first edge, none while bit already set
    repeat (3) @(negedge clk);
    cts_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8", "chg before edge seen", {7'b0, chg_flag}, 8'h00);
    @(negedge clk);
    check("R8", "chg pulse", {7'b0, chg_flag}, 8'h01);
    @(negedge clk);
    check("R8", "chg pulse ends", {7'b0, chg_flag}, 8'h00);
    cts_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", "no chg while bit set", {7'b0, chg_flag}, 8'h00);
    do_read();
    check("R4", "cts toggled twice", rd_data, 8'h01);

    // R6 edge arriving on the read edge is kept
    repeat (2) @(negedge clk);
    cts_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R6", "read on edge returns old deltas", rd_data, 8'h10);
    check("R8", "chg on read edge", {7'b0, chg_flag}, 8'h01);
    do_read();
    check("R6", "edge kept after read", rd_data, 8'h11);
    do_read();
    check("R6", "cleared after read", rd_data, 8'h10);

    // R9 reset in mid-operation
    wr_en = 1'b1; wr_data = 8'h0F;
    @(negedge clk);
    wr_en = 1'b0;
    check("R2", "all outputs active", pins_out(), 8'h00);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9", "pins after second reset", pins_out(), 8'h0F);
    check("R9", "rd_data after second reset", rd_data, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule